// File: doc/BRIEF.md
# CAN Transmit Queue with Safe Disable

This block keeps one message queue that feeds a CAN protocol engine. It stores pushed messages in order and keeps a message count, with an empty flag derived from that count. It also holds a transmit-interrupt flag that software clears. The block takes part in choosing the next sender. When the queue may transmit and the engine reports either an idle bus or the CRC delimiter of a frame that another node is sending, the block runs a short priority decision. If the queue can still transmit when the decision ends, it raises a transmit request. It then follows the frame through start of frame to its end.

Software disables the queue by clearing its enable. If the queue is idle, the disable takes effect at once. If the queue is inside a priority decision, is the chosen sender, or has a frame on the bus, the disable is held back. Only an error or a lost arbitration can cut a frame short. Once the blocking activity is over, the block waits a fixed internal delay, then empties the queue.

Top module: `txq_abort_top`

## Requirements
- R1: A priority decision starts only when the block is idle and one of evBusIdle or evCrcDelim is high, the enable is 1, the depth code is not 000b and the count is at least 1. decideActive is 1 in the cycle after the start event; under any other conditions it stays 0.
- R2: A decision lasts DECIDE_CYC cycles (2 by default). When it ends while the queue can still transmit, txReq goes to 1. An evSof pulse then clears txReq and sets txSending in the following cycle.
- R3: A CRC delimiter event from a frame that another node owns starts a decision exactly as a bus-idle event does.
- R4: Clearing the enable while txReq or txSending is 1 does not abort the frame. txReq and txSending hold, and the count is unchanged until evDone, evError or evArbLost.
- R5: evDone while sending lowers the count by one in the next cycle, and txData moves to the next message in push order.
- R6: When cfgIrqEvery is 1, each evDone while sending sets txIrqFlag in the next cycle, and the flag stays set until an irqClear pulse. When cfgIrqEvery is 0, evDone leaves the flag at 0.
- R7: Clearing the enable during a decision defers the disable. The count and the empty flag hold through the cycle in which the decision ends and for one more cycle. The count then becomes 0 and emptyFlag becomes 1, two cycles after the block returns to idle.
- R8: Clearing the enable while the block is idle, not chosen and not deciding clears the count and sets emptyFlag in the next cycle.
- R9: evError or evArbLost while sending with a disable pending ends the frame without lowering the count. The disable then completes two cycles later.
- R10: A push is ignored when the enable is 0, when a disable is pending, or when the count equals the capacity. Capacities by depth code: 000b gives 0, 001b gives 4, 010b gives 8, 011b gives 16, 100b gives 32, 101b gives 48, and 110b and 111b give 63 (the count saturates at 63).
- R11: After reset the count is 0, emptyFlag is 1, and txIrqFlag, txReq, txSending and decideActive are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEnable | input | 1 | Queue enable; a 1-to-0 change requests disable |
| cfgDepth | input | 3 | Depth code |
| cfgIrqEvery | input | 1 | Set the interrupt flag after every sent message |
| irqClear | input | 1 | Software clear of txIrqFlag |
| pushValid | input | 1 | Push request |
| pushData | input | DATA_W | Message pushed |
| evBusIdle | input | 1 | Engine reports an idle bus |
| evSof | input | 1 | Start of frame for this queue's message |
| evCrcDelim | input | 1 | CRC delimiter of the current frame on the bus |
| evDone | input | 1 | Frame sent successfully |
| evError | input | 1 | Bus error ended the frame |
| evArbLost | input | 1 | Arbitration lost |
| txReq | output | 1 | Queue chosen as next sender |
| txSending | output | 1 | Queue's frame is on the bus |
| decideActive | output | 1 | Priority decision running |
| txData | output | DATA_W | Head message |
| msgCount | output | CNT_W | Stored message count |
| emptyFlag | output | 1 | Count is zero |
| txIrqFlag | output | 1 | Transmit interrupt flag |

## Verification
Every status output comes from a register, so each result is due one edge after the stimulus that causes it. A decision adds DECIDE_CYC edges before txReq, and a deferred disable adds two edges after the return to idle. The bench drives inputs and samples outputs on the falling edge. It steps exactly the number of rising edges that the requirement's timing calls for before each check. For the deferred cases it also checks the intermediate cycles, which shows the count does not clear one edge early. The capacity sweep covers all eight depth codes and overfills each one, with the expected counts computed in the bench.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DECIDE, ST_CHOSEN, ST_SEND} txqState_e;
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } txqStrobe_t;
endpackage

// File: rtl/txq_store.sv
`timescale 1ns/1ps
module txq_store
  import txq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  txqStrobe_t        strb,
  input  logic [DATA_W-1:0] pushData,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] headData
);
  localparam int SLOTS = 1 << CNT_W;

  logic [DATA_W-1:0] slotMem [SLOTS];
  logic [CNT_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strb.push) slotMem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
      if (strb.push && !strb.pop)      count <= count + 1'b1;
      else if (strb.pop && !strb.push) count <= count - 1'b1;
    end
  end

  assign headData = slotMem[rdPtr];

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> count == '0);
  // R5
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push && !strb.clear) |=> count == $past(count) - 1'b1);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.pop) |-> count != '1);
endmodule

// File: rtl/txq_ctrl.sv
`timescale 1ns/1ps
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int DECIDE_CYC  = 2,
  parameter int DISABLE_DLY = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [2:0]       cfgDepth,
  input  logic             cfgIrqEvery,
  input  logic             irqClear,
  input  logic             pushValid,
  input  logic             evBusIdle,
  input  logic             evSof,
  input  logic             evCrcDelim,
  input  logic             evDone,
  input  logic             evError,
  input  logic             evArbLost,
  input  logic [CNT_W-1:0] count,
  output txqStrobe_t       strb,
  output logic             txReq,
  output logic             txSending,
  output logic             decideActive,
  output logic             txIrqFlag
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int DEC_W   = $clog2(DECIDE_CYC + 1);
  localparam int DLY_W   = $clog2(DISABLE_DLY + 1);

  function automatic logic [CNT_W-1:0] depthCap(input logic [2:0] code);
    int raw;
    case (code)
      3'd0:    raw = 0;
      3'd1:    raw = 4;
      3'd2:    raw = 8;
      3'd3:    raw = 16;
      3'd4:    raw = 32;
      3'd5:    raw = 48;
      3'd6:    raw = 64;
      default: raw = 128;
    endcase
    if (raw > CNT_MAX) raw = CNT_MAX;
    return CNT_W'(raw);
  endfunction

  txqState_e        state, stateNext;
  logic [DEC_W-1:0] decCnt;
  logic [DLY_W-1:0] dlyCnt;
  logic             enPrev, disPending;
  logic             canSend, enFall, startDec, decLast, abortEv, clearNow;

  assign canSend  = cfgEnable && (cfgDepth != 3'd0) && (count != '0) && !disPending;
  assign enFall   = enPrev && !cfgEnable;
  assign startDec = (state == ST_IDLE) && canSend && (evBusIdle || evCrcDelim);
  assign decLast  = (decCnt == DEC_W'(DECIDE_CYC - 1));
  assign abortEv  = evError || evArbLost;
  assign clearNow = (state == ST_IDLE) &&
                    ((enFall && !disPending) ||
                     (disPending && dlyCnt == DLY_W'(DISABLE_DLY - 1)));

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (startDec) stateNext = ST_DECIDE;
      ST_DECIDE: if (decLast) stateNext = canSend ? ST_CHOSEN : ST_IDLE;
      ST_CHOSEN: if (abortEv) stateNext = ST_IDLE;
                 else if (evSof) stateNext = ST_SEND;
      ST_SEND:   if (evDone || abortEv) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.clear = clearNow;
    strb.pop   = (state == ST_SEND) && evDone;
    strb.push  = pushValid && cfgEnable && !disPending && !clearNow &&
                 (count < depthCap(cfgDepth));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      decCnt     <= '0;
      dlyCnt     <= '0;
      enPrev     <= 1'b0;
      disPending <= 1'b0;
      txIrqFlag  <= 1'b0;
    end else begin
      state  <= stateNext;
      enPrev <= cfgEnable;
      decCnt <= (state == ST_DECIDE && !decLast) ? decCnt + 1'b1 : '0;
      if (clearNow)                        disPending <= 1'b0;
      else if (enFall && state != ST_IDLE) disPending <= 1'b1;
      dlyCnt <= (disPending && state == ST_IDLE && !clearNow) ? dlyCnt + 1'b1 : '0;
      if (strb.pop && cfgIrqEvery) txIrqFlag <= 1'b1;
      else if (irqClear)           txIrqFlag <= 1'b0;
    end
  end

  assign txReq        = (state == ST_CHOSEN);
  assign txSending    = (state == ST_SEND);
  assign decideActive = (state == ST_DECIDE);

  // R1
  dec_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decideActive) |-> $past(cfgEnable && cfgDepth != 3'd0 && count != '0));
  // R4
  send_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txSending && !evDone && !abortEv) |=> txSending);
  // R4
  chosen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !evSof && !abortEv) |=> txReq);
  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIrqFlag) |-> $past(txSending && evDone && cfgIrqEvery));
  // R7
  defer_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (disPending && (decideActive || txReq)) |=> count == $past(count));
endmodule

// File: rtl/txq_abort_top.sv
`timescale 1ns/1ps
module txq_abort_top
  import txq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 6,
  parameter int DECIDE_CYC  = 2,
  parameter int DISABLE_DLY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [2:0]        cfgDepth,
  input  logic              cfgIrqEvery,
  input  logic              irqClear,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              evBusIdle,
  input  logic              evSof,
  input  logic              evCrcDelim,
  input  logic              evDone,
  input  logic              evError,
  input  logic              evArbLost,
  output logic              txReq,
  output logic              txSending,
  output logic              decideActive,
  output logic [DATA_W-1:0] txData,
  output logic [CNT_W-1:0]  msgCount,
  output logic              emptyFlag,
  output logic              txIrqFlag
);
  txqStrobe_t strb;

  txq_ctrl #(.CNT_W(CNT_W), .DECIDE_CYC(DECIDE_CYC), .DISABLE_DLY(DISABLE_DLY)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgDepth(cfgDepth),
    .cfgIrqEvery(cfgIrqEvery), .irqClear(irqClear), .pushValid(pushValid),
    .evBusIdle(evBusIdle), .evSof(evSof), .evCrcDelim(evCrcDelim), .evDone(evDone),
    .evError(evError), .evArbLost(evArbLost), .count(msgCount), .strb(strb),
    .txReq(txReq), .txSending(txSending), .decideActive(decideActive),
    .txIrqFlag(txIrqFlag)
  );

  txq_store #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .pushData(pushData),
    .count(msgCount), .headData(txData)
  );

  assign emptyFlag = (msgCount == '0);
endmodule

// File: tb/tb_txq_abort_top.sv
`timescale 1ns/1ps
module tb_txq_abort_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgEnable = 1'b0, cfgIrqEvery = 1'b0, irqClear = 1'b0;
  logic [2:0] cfgDepth = 3'd0;
  logic       pushValid = 1'b0;
  logic [7:0] pushData = 8'd0;
  logic       evBusIdle = 1'b0, evSof = 1'b0, evCrcDelim = 1'b0;
  logic       evDone = 1'b0, evError = 1'b0, evArbLost = 1'b0;
  logic       txReq, txSending, decideActive, emptyFlag, txIrqFlag;
  logic [7:0] txData;
  logic [5:0] msgCount;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  txq_abort_top dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgDepth(cfgDepth),
    .cfgIrqEvery(cfgIrqEvery), .irqClear(irqClear), .pushValid(pushValid),
    .pushData(pushData), .evBusIdle(evBusIdle), .evSof(evSof),
    .evCrcDelim(evCrcDelim), .evDone(evDone), .evError(evError),
    .evArbLost(evArbLost), .txReq(txReq), .txSending(txSending),
    .decideActive(decideActive), .txData(txData), .msgCount(msgCount),
    .emptyFlag(emptyFlag), .txIrqFlag(txIrqFlag)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pushSome(input int n, input int base);
    pushValid = 1'b1;
    for (int i = 0; i < n; i++) begin
      pushData = 8'(base + i);
      step();
    end
    pushValid = 1'b0;
  endtask

  function automatic int capOf(input int code);
    int c;
    if (code == 0) c = 0;
    else if (code <= 4) c = 4 << (code - 1);
    else if (code == 5) c = 48;
    else c = 64 << (code - 6);
    return (c > 63) ? 63 : c;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R11 reset state
    check("R11 count", msgCount, 0);
    check("R11 empty", emptyFlag, 1);
    check("R11 irq", txIrqFlag, 0);
    check("R11 req", txReq, 0);
    check("R11 send", txSending, 0);
    check("R11 decide", decideActive, 0);

    // R10 capacity sweep over every depth code, R8 immediate disable
    for (int d = 0; d < 8; d++) begin
      cfgDepth = 3'(d);
      cfgEnable = 1'b1;
      pushSome(70, d * 10);
      check("R10 capacity", msgCount, capOf(d));
      check("R10 empty", emptyFlag, (capOf(d) == 0) ? 1 : 0);
      cfgEnable = 1'b0;
      step();
      check("R8 count", msgCount, 0);
      check("R8 empty", emptyFlag, 1);
      pushSome(3, 0);
      check("R10 disabled push", msgCount, 0);
    end

    // R1, R2, R5, R6 basic transmission
    cfgEnable = 1'b1;
    cfgDepth = 3'd1;
    cfgIrqEvery = 1'b1;
    pushSome(3, 8'hA0);
    check("R5 head", txData, 8'hA0);
    cfgDepth = 3'd0;
    evBusIdle = 1'b1; step(); evBusIdle = 1'b0;
    check("R1 depth0 blocks", decideActive, 0);
    cfgDepth = 3'd1;
    step();
    check("R1 no event", decideActive, 0);
    evBusIdle = 1'b1; step(); evBusIdle = 1'b0;
    check("R1 start", decideActive, 1);
    step();
    check("R2 still deciding", decideActive, 1);
    check("R2 req low", txReq, 0);
    step();
    check("R2 decide end", decideActive, 0);
    check("R2 req", txReq, 1);
    evSof = 1'b1; step(); evSof = 1'b0;
    check("R2 sending", txSending, 1);
    check("R2 req dropped", txReq, 0);
    evDone = 1'b1; step(); evDone = 1'b0;
    check("R5 count", msgCount, 2);
    check("R5 next head", txData, 8'hA1);
    check("R6 irq set", txIrqFlag, 1);
    step(); step();
    check("R6 irq held", txIrqFlag, 1);
    irqClear = 1'b1; step(); irqClear = 1'b0;
    check("R6 irq cleared", txIrqFlag, 0);
    cfgIrqEvery = 1'b0;
    evBusIdle = 1'b1; step(); evBusIdle = 1'b0;
    step(); step();
    evSof = 1'b1; step(); evSof = 1'b0;
    evDone = 1'b1; step(); evDone = 1'b0;
    check("R5 count again", msgCount, 1);
    check("R6 irq off mode", txIrqFlag, 0);

    // R3 start on CRC delimiter, R4 disable while chosen and sending
    pushSome(2, 8'hB0);
    check("R3 count before", msgCount, 3);
    evCrcDelim = 1'b1; step(); evCrcDelim = 1'b0;
    check("R3 start", decideActive, 1);
    step(); step();
    check("R3 req", txReq, 1);
    cfgEnable = 1'b0;
    step();
    check("R4 req kept", txReq, 1);
    check("R4 count kept", msgCount, 3);
    evSof = 1'b1; step(); evSof = 1'b0;
    check("R4 sending", txSending, 1);
    step(); step();
    check("R4 still sending", txSending, 1);
    check("R4 count during frame", msgCount, 3);
    evDone = 1'b1; step(); evDone = 1'b0;
    check("R4 frame completed", msgCount, 2);
    step();
    check("R4 defer hold", msgCount, 2);
    step();
    check("R4 defer done", msgCount, 0);
    check("R4 empty", emptyFlag, 1);

    // R7 disable during decision is deferred
    cfgEnable = 1'b1;
    step();
    pushSome(2, 8'hC0);
    evCrcDelim = 1'b1; step(); evCrcDelim = 1'b0;
    check("R7 deciding", decideActive, 1);
    cfgEnable = 1'b0;
    step();
    check("R7 count held", msgCount, 2);
    check("R7 empty held", emptyFlag, 0);
    step();
    check("R7 decision ended", decideActive, 0);
    check("R7 not chosen", txReq, 0);
    check("R7 count at idle", msgCount, 2);
    step();
    check("R7 count delay", msgCount, 2);
    check("R7 empty delay", emptyFlag, 0);
    step();
    check("R7 cleared", msgCount, 0);
    check("R7 empty set", emptyFlag, 1);

    // R9 error or arbitration loss with pending disable
    for (int k = 0; k < 2; k++) begin
      cfgEnable = 1'b1;
      step();
      pushSome(2, 8'hD0);
      evBusIdle = 1'b1; step(); evBusIdle = 1'b0;
      step(); step();
      evSof = 1'b1; step(); evSof = 1'b0;
      cfgEnable = 1'b0;
      step();
      if (k == 0) evError = 1'b1; else evArbLost = 1'b1;
      step();
      evError = 1'b0; evArbLost = 1'b0;
      check("R9 frame ended", txSending, 0);
      check("R9 no decrement", msgCount, 2);
      step();
      check("R9 delay", msgCount, 2);
      step();
      check("R9 cleared", msgCount, 0);
      check("R9 empty", emptyFlag, 1);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule